// File: doc/BRIEF.md
# Cascaded Serial DAC Chain Loader

This controller sits on the host side of a string of 16-bit serial converters. The converters are wired in a chain: each serial data output feeds the next device's serial data input. All devices share one serial clock, one shift-enable line and one update line. The host puts one code per device on a parallel bus and pulses `start`. The controller then generates every serial clock edge itself. It streams all words as one continuous bit stream, most significant bit first, in straight binary. The word for the farthest device goes out first, so that at the end each device holds its own word.

After the last shift edge the controller raises the shift enable. It then pulls the update line low and gives exactly one further clock strobe, so that every converter moves its word to its output at the same moment. It then pulses `done` and returns to an idle bus: clock low and both enables high. A separate `clear_req` input, accepted only while idle, drives the active-low clear line for a programmed width.

All analog timing minimums are given as counts of system-clock cycles, set by parameters:
- clock low width and clock high width;
- setup and hold of data and enables around a rising clock edge;
- clear pulse width.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset and whenever `busy` is low, `sclk` is 0, `shift_en_n` is 1, `update_n` is 1, `clear_n` is 1 and `done` is 0.
- R2: One load produces exactly 16·N_DEV rising `sclk` edges while `shift_en_n` is 0.
- R3: The stream carries `codes[16k+15:16k]` for device k, where device 0 is nearest the host. The bit order is `codes[16·N_DEV-1]` first down to `codes[0]` last. A model chain that shifts `sdata` in at its LSB on each shift edge therefore ends equal to `codes`.
- R4: After the shift edges, exactly one rising `sclk` edge occurs with `update_n` 0. At that edge `shift_en_n` is 1. `update_n` is never 0 while `shift_en_n` is 0.
- R5: Every low phase of `sclk` lasts at least CLK_LOW_CYC cycles and every high phase lasts at least CLK_HIGH_CYC cycles.
- R6: `sdata` is stable for at least SETUP_CYC cycles before each shift edge. It does not change within HOLD_CYC cycles after any rising `sclk` edge.
- R7: Each enable falls at least SETUP_CYC cycles before its first rising `sclk` edge. It rises no sooner than HOLD_CYC cycles after its last one.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle after `done`. A `start` pulse while busy is ignored. The codes are captured at the accepted `start`, so later changes on `codes` do not alter the stream.
- R9: `done` is high for exactly one cycle per load. In the next cycle `busy` is low and the bus is idle.
- R10: A `clear_req` pulse while idle drives `clear_n` low for exactly CLEAR_CYC cycles, with `busy` high and no `sclk` activity. Afterwards `clear_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled only while idle) |
| clear_req | input | 1 | Request a clear pulse (sampled only while idle, lower priority than start) |
| codes | input | 16·N_DEV | Packed codes, device k at bits [16k+15:16k] |
| busy | output | 1 | Load or clear in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the first device |
| shift_en_n | output | 1 | Active-low shift enable for the input registers |
| update_n | output | 1 | Active-low enable for the output latches |
| clear_n | output | 1 | Active-low clear to all devices |

## Verification
The bench uses a chain model that shifts `sdata` in on every shift edge. It uses code patterns around the major carry (0x7FFF/0x8000), all zeros, all ones and alternating bits. A word order or bit order error then leaves a chain value different from `codes`. An off-by-one bit counter shows up as 47 or 49 shift edges. A strobe that overlaps the shift phase shows up as an update edge with the shift enable still low. A phase monitor measures every clock phase and every data and enable edge against the minimums, so a design that shortens a setup or hold window by one cycle is caught. It also starts a second load while busy and changes `codes` mid-stream, and a design that honours either leaves extra edges or a corrupted chain. The clear is timed to the exact cycle count.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_TAIL,
        ST_UPD_SET,
        ST_UPD_HI,
        ST_UPD_TAIL,
        ST_DONE,
        ST_CLEAR
    } dcl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcl_phase_timer.sv
module dcl_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: a phase that is still running keeps counting down toward expiry
    assert_timer_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/dcl_word_shifter.sv
module dcl_word_shifter #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)
            sr_d = par_in;
        else if (step)
            sr_d = {sr_q[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign ser_out = sr_q[WIDTH-1];

    // R3: the first bit on the line is the top bit of the farthest device's word
    assert_load_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_out == $past(par_in[WIDTH-1])));
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
    import dcl_pkg::*;
#(
    parameter int N_DEV        = 3,
    parameter int WORD_W       = 16,
    parameter int CLK_LOW_CYC  = 3,
    parameter int CLK_HIGH_CYC = 2,
    parameter int SETUP_CYC    = 4,
    parameter int HOLD_CYC     = 3,
    parameter int CLEAR_CYC    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    clear_req,
    input  logic [N_DEV*WORD_W-1:0] codes,
    output logic                    busy,
    output logic                    done,
    output logic                    sclk,
    output logic                    sdata,
    output logic                    shift_en_n,
    output logic                    update_n,
    output logic                    clear_n
);
    localparam int TOTAL    = N_DEV * WORD_W;
    localparam int CW       = $clog2(TOTAL);
    localparam int LO_DUR   = imax(CLK_LOW_CYC, SETUP_CYC);
    localparam int HI_DUR   = imax(CLK_HIGH_CYC, HOLD_CYC);
    localparam int TAIL_DUR = imax(HOLD_CYC, 1);
    localparam int MAX_DUR  = imax(imax(LO_DUR, HI_DUR), imax(TAIL_DUR, CLEAR_CYC));
    localparam int TW       = $clog2(MAX_DUR + 1);

    typedef struct packed {
        dcl_state_e    state;
        logic [CW-1:0] bitcnt;
        logic          sclk;
        logic          a0_n;
        logic          a1_n;
        logic          clr_n;
        logic          done;
        logic          busy;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          sh_load;
    logic          sh_step;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        sh_step    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    sh_load      = 1'b1;
                    ctl_d.state  = ST_LO;
                    ctl_d.a0_n   = 1'b0;
                    ctl_d.busy   = 1'b1;
                    ctl_d.bitcnt = '0;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(LO_DUR - 1);
                end else if (clear_req) begin
                    ctl_d.state = ST_CLEAR;
                    ctl_d.clr_n = 1'b0;
                    ctl_d.busy  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(CLEAR_CYC - 1);
                end
            end
            ST_LO: if (tmr_exp) begin
                ctl_d.state = ST_HI;
                ctl_d.sclk  = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = TW'(HI_DUR - 1);
            end
            ST_HI: if (tmr_exp) begin
                ctl_d.sclk = 1'b0;
                tmr_load   = 1'b1;
                if (ctl_q.bitcnt == CW'(TOTAL - 1)) begin
                    ctl_d.state = ST_TAIL;
                    tmr_val     = TW'(TAIL_DUR - 1);
                end else begin
                    ctl_d.state  = ST_LO;
                    ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                    sh_step      = 1'b1;
                    tmr_val      = TW'(LO_DUR - 1);
                end
            end
            ST_TAIL: if (tmr_exp) begin
                ctl_d.state = ST_UPD_SET;
                ctl_d.a0_n  = 1'b1;
                ctl_d.a1_n  = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = TW'(LO_DUR - 1);
            end
            ST_UPD_SET: if (tmr_exp) begin
                ctl_d.state = ST_UPD_HI;
                ctl_d.sclk  = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = TW'(HI_DUR - 1);
            end
            ST_UPD_HI: if (tmr_exp) begin
                ctl_d.state = ST_UPD_TAIL;
                ctl_d.sclk  = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = TW'(TAIL_DUR - 1);
            end
            ST_UPD_TAIL: if (tmr_exp) begin
                ctl_d.state = ST_DONE;
                ctl_d.a1_n  = 1'b1;
                ctl_d.done  = 1'b1;
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
                ctl_d.busy  = 1'b0;
            end
            ST_CLEAR: if (tmr_exp) begin
                ctl_d.state = ST_IDLE;
                ctl_d.clr_n = 1'b1;
                ctl_d.busy  = 1'b0;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.bitcnt <= '0;
            ctl_q.sclk   <= 1'b0;
            ctl_q.a0_n   <= 1'b1;
            ctl_q.a1_n   <= 1'b1;
            ctl_q.clr_n  <= 1'b1;
            ctl_q.done   <= 1'b0;
            ctl_q.busy   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dcl_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dcl_word_shifter #(.WIDTH(TOTAL)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .step    (sh_step),
        .par_in  (codes),
        .ser_out (sdata)
    );

    assign busy       = ctl_q.busy;
    assign done       = ctl_q.done;
    assign sclk       = ctl_q.sclk;
    assign shift_en_n = ctl_q.a0_n;
    assign update_n   = ctl_q.a1_n;
    assign clear_n    = ctl_q.clr_n;

    // R1: an idle controller leaves the bus quiet
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.busy |-> (!ctl_q.sclk && ctl_q.a0_n && ctl_q.a1_n && ctl_q.clr_n));

    // R2: the shift phase only ends after the last bit has been clocked
    assert_tail_after_last_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_TAIL) |-> (ctl_q.bitcnt == CW'(TOTAL - 1)));

    // R4: shift enable and update enable are never active together
    assert_enables_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.a0_n || ctl_q.a1_n));

    // R5: the clock high phase cannot end before its timer expires
    assert_sclk_high_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sclk && !tmr_exp) |=> ctl_q.sclk);

    // R9: done is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);

    // R10: no clock or enable activity while clear is driven
    assert_clear_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.clr_n |-> (!ctl_q.sclk && ctl_q.a0_n && ctl_q.a1_n && ctl_q.busy));
endmodule

// File: tb/tb_dac_chain_loader.sv
module tb_dac_chain_loader;
    localparam int N     = 3;
    localparam int TOTAL = N * 16;
    localparam int LOWC  = 3;
    localparam int HIGHC = 2;
    localparam int SUC   = 4;
    localparam int HDC   = 3;
    localparam int CLRC  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             clear_req = 1'b0;
    logic [TOTAL-1:0] codes = '0;
    logic busy, done, sclk, sdata, shift_en_n, update_n, clear_n;

    dac_chain_loader #(
        .N_DEV(N), .WORD_W(16), .CLK_LOW_CYC(LOWC), .CLK_HIGH_CYC(HIGHC),
        .SETUP_CYC(SUC), .HOLD_CYC(HDC), .CLEAR_CYC(CLRC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear_req(clear_req),
        .codes(codes), .busy(busy), .done(done), .sclk(sclk), .sdata(sdata),
        .shift_en_n(shift_en_n), .update_n(update_n), .clear_n(clear_n)
    );

    always #2.5 clk = ~clk;

    int errs = 0;
    int checks = 0;

    // bus monitor state
    logic             p_sclk = 1'b0, p_sdata = 1'b0, p_a0 = 1'b1, p_a1 = 1'b1;
    int               sc_run = 1000, sd_run = 1000, a0_run = 1000, a1_run = 1000, rise_run = 1000;
    int               shift_edges = 0, upd_edges = 0, upd_at = 0, done_cnt = 0;
    int               v4 = 0, v5 = 0, v6 = 0, v7 = 0;
    logic [TOTAL-1:0] chain = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !p_sclk) rise_run = 0;
            else rise_run = rise_run + 1;
            if (sclk && !p_sclk) begin
                if (sc_run + 1 < LOWC) v5++;
                if (!shift_en_n) begin
                    shift_edges++;
                    chain = {chain[TOTAL-2:0], sdata};
                    if (sd_run + 1 < SUC) v6++;
                    if (a0_run + 1 < SUC) v7++;
                end
                if (!update_n) begin
                    upd_edges++;
                    upd_at = shift_edges;
                    if (!shift_en_n) v4++;
                    if (a1_run + 1 < SUC) v7++;
                end
            end
            if (!sclk && p_sclk && sc_run + 1 < HIGHC) v5++;
            if (sdata != p_sdata && rise_run < HDC) v6++;
            if (shift_en_n && !p_a0 && rise_run < HDC) v7++;
            if (update_n && !p_a1 && rise_run < HDC) v7++;
            if (!shift_en_n && !update_n) v4++;
            if (done) done_cnt++;
            sc_run = (sclk != p_sclk) ? 0 : sc_run + 1;
            sd_run = (sdata != p_sdata) ? 0 : sd_run + 1;
            a0_run = (shift_en_n != p_a0) ? 0 : a0_run + 1;
            a1_run = (update_n != p_a1) ? 0 : a1_run + 1;
            p_sclk = sclk; p_sdata = sdata; p_a0 = shift_en_n; p_a1 = update_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        shift_edges = 0; upd_edges = 0; upd_at = 0; done_cnt = 0;
        v4 = 0; v5 = 0; v6 = 0; v7 = 0; chain = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic check_idle(input string req);
        chk(!busy && !sclk && shift_en_n && update_n && clear_n && !done, req, "idle bus",
            {58'd0, busy, sclk, shift_en_n, update_n, clear_n, done}, 64'b001110);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic t_load(input logic [TOTAL-1:0] val);
        bit seen;
        clear_mon();
        codes = val;
        pulse_start();
        chk(busy, "R8", "busy after start", busy, 1);
        wait_done(seen);
        chk(seen, "R9", "done seen", seen, 1);
        @(negedge clk);
        chk(!done && done_cnt == 1, "R9", "done width", done_cnt, 1);
        check_idle("R9");
        chk(shift_edges == TOTAL, "R2", "shift edges", shift_edges, TOTAL);
        chk(chain == val, "R3", "chain contents", chain, val);
        chk(upd_edges == 1 && upd_at == TOTAL, "R4", "update strobe", upd_edges, 1);
        chk(v4 == 0, "R4", "enable overlap", v4, 0);
        chk(v5 == 0, "R5", "clock phase violations", v5, 0);
        chk(v6 == 0, "R6", "data setup/hold violations", v6, 0);
        chk(v7 == 0, "R7", "enable setup/hold violations", v7, 0);
    endtask

    task automatic t_busy_start();
        bit seen;
        logic [TOTAL-1:0] first = {16'h1234, 16'hBEEF, 16'h0F0F};
        clear_mon();
        codes = first;
        pulse_start();
        repeat (40) @(negedge clk);
        codes = ~first;
        chk(busy, "R8", "busy mid-load", busy, 1);
        pulse_start();
        wait_done(seen);
        repeat (60) @(negedge clk);
        chk(shift_edges == TOTAL && upd_edges == 1, "R8", "edges with start while busy",
            shift_edges, TOTAL);
        chk(chain == first, "R8", "codes captured at start", chain, first);
        chk(done_cnt == 1, "R8", "single done", done_cnt, 1);
        check_idle("R8");
    endtask

    task automatic t_clear();
        int low = 0;
        bit busy_ok = 1'b1;
        clear_mon();
        @(negedge clk) clear_req = 1'b1;
        @(negedge clk) clear_req = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (clear_n) break;
            low++;
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
        end
        chk(low == CLRC, "R10", "clear width", low, CLRC);
        chk(busy_ok, "R10", "busy during clear", busy_ok, 1);
        chk(shift_edges == 0 && upd_edges == 0, "R10", "no clock in clear",
            shift_edges + upd_edges, 0);
        check_idle("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load({16'h8000, 16'h7FFF, 16'h0001});
        t_load({16'hAAAA, 16'h5555, 16'hA5A5});
        t_load('0);
        t_load('1);
        t_busy_start();
        t_clear();
        t_load({16'hC001, 16'h0000, 16'hFFFE});
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule